// File: doc/BRIEF.md
# FIFO-Commanded GPIO Port Expander

This block turns a byte stream arriving through an asynchronous, byte-wide USB FIFO bridge into accesses on 48 general-purpose pins, grouped as six 8-bit ports. It pulls bytes from the bridge with an active-low read strobe whenever the bridge reports received data. Each command byte names a port and an operation. A set command writes the byte that follows into that port's output-value register or its direction register. A read command samples the port's synchronised pin levels and pushes one reply byte back into the bridge with an active-low write strobe.

Each pin leaves the block as an output value and an output-enable for a pad tristate buffer. Its level comes back in on a separate input. A host can pack many commands into one transfer, and the block executes them strictly in arrival order. Reply bytes therefore queue up in the bridge in the same order as the read commands that produced them.

Top module: `gpio_fifo_expander`

## Requirements
- R1: Port p (0 to 5) owns pins 8p to 8p+7 of the 48-bit pin vectors, with bit i of a port byte mapped to pin 8p+i.
- R2: A command byte has bits [7:5] equal to zero, an operation in bits [4:3] (0 = read port, 1 = set output value, 2 = set direction) and a port index in bits [2:0].
- R3: A set command consumes exactly the next byte as its data. The addressed register takes that byte on the clock edge that ends the data byte's read strobe, and no pin register changes at any other time.
- R4: A read command consumes no data byte and produces one reply byte: the pin levels of the addressed port after a two-stage synchroniser. A level held stable for at least three cycles before the command's read strobe ends is the one reported.
- R5: A direction bit of 1 makes the pin an input (output-enable low). A direction bit of 0 drives the pin with the corresponding output-value bit.
- R6: After reset every direction bit is 1, so all output-enables are low, and every output-value bit is 0.
- R7: Commands received back to back are executed in order with none lost. A burst of reads returns one reply per read, in command order, including a read that follows a set of the same port.
- R8: The read strobe only falls after the receive-empty flag (active low) was seen low, and stays low for RD_CYC cycles. Each byte is fetched exactly once.
- R9: The write strobe only falls after the transmit-full flag (active low) was seen low, stays low for WR_CYC cycles with the reply byte stable and the data bus enabled, and never starts while the flag is high.
- R10: A command with bits [7:5] non-zero, operation 3, or port index 6 or 7 changes nothing and consumes no data byte, so the following byte is taken as a command.
- R11: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxf_n | input | 1 | Bridge has received data (active low) |
| fifo_din | input | 8 | Byte from the bridge, valid while rd_n is low |
| rd_n | output | 1 | Read strobe to the bridge (active low) |
| txe_n | input | 1 | Bridge can accept a byte (active low) |
| fifo_dout | output | 8 | Reply byte to the bridge |
| fifo_dout_oe | output | 1 | Enable for the bridge data bus driver during a write |
| wr_n | output | 1 | Write strobe to the bridge (active low) |
| pin_in | input | 48 | Pad levels of all pins |
| pin_out | output | 48 | Output value for each pin |
| pin_oe | output | 48 | Output enable for each pin tristate buffer (1 = drive) |

## Verification
The bench builds the block with six ports, a two-cycle read strobe and a three-cycle write strobe. The longer write strobe shows that the strobe length follows its parameter and is not fixed at the minimum. With six ports, indices 6 and 7 fall outside the port range, so the no-op path for out-of-range commands is reached alongside reserved operations and non-zero upper bits. The bench stalls the transmit flag, trickles bytes with gaps, and places a read right after a set of the same port, which exercises ordering and synchroniser latency.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_SETVAL = 2'd1,
    OP_SETDIR = 2'd2,
    OP_RSVD   = 2'd3
  } gpx_op_e;

  function automatic gpx_op_e cmd_op(input logic [7:0] b);
    return gpx_op_e'(b[4:3]);
  endfunction

  function automatic logic [2:0] cmd_port(input logic [7:0] b);
    return b[2:0];
  endfunction

  // A command is usable when its upper bits are clear, the operation is
  // defined and the port exists.
  function automatic logic cmd_valid(input logic [7:0] b, input int unsigned nports);
    return (b[7:5] == 3'b000) && (b[4:3] != 2'b11) && (int'(b[2:0]) < nports);
  endfunction

endpackage

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpx_port_bank.sv
`timescale 1ns/1ps
module gpx_port_bank #(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic                          to_dir,
  input  logic [2:0]                    port,
  input  logic [PORT_W-1:0]             data,
  output logic [NUM_PORTS*PORT_W-1:0]   out_flat,
  output logic [NUM_PORTS*PORT_W-1:0]   oe_flat
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] val_q;
    logic [PORT_W-1:0] dir_q;
    wire hit = we && (port == 3'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        dir_q <= '1;
      end else if (hit) begin
        if (to_dir) dir_q <= data;
        else        val_q <= data;
      end
    end

    assign out_flat[p*PORT_W +: PORT_W] = val_q;
    assign oe_flat[p*PORT_W +: PORT_W]  = ~dir_q;
  end
endmodule

// File: rtl/gpx_fifo_ctrl.sv
`timescale 1ns/1ps
module gpx_fifo_ctrl
  import gpx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned RD_CYC    = 2,
  parameter int unsigned WR_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxf_n,
  input  logic [PORT_W-1:0] fifo_din,
  output logic              rd_n,
  input  logic              txe_n,
  output logic [PORT_W-1:0] fifo_dout,
  output logic              fifo_dout_oe,
  output logic              wr_n,
  output logic [2:0]        look_port,
  input  logic [PORT_W-1:0] reply_byte,
  output logic              reg_we,
  output logic              reg_dir,
  output logic [2:0]        reg_port,
  output logic [PORT_W-1:0] reg_data,
  output logic              byte_done,
  output logic              cmd_drop
);
  localparam int unsigned MAXC  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT_TX, ST_SEND} st_e;

  st_e                st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rd_n_q, wr_n_q;
  logic               pend_q, pend_dir_q;
  logic [2:0]         pend_port_q;
  logic [PORT_W-1:0]  reply_q;

  wire fetch_done = (st_q == ST_FETCH) && (cnt_q == CNT_W'(RD_CYC - 1));
  wire send_done  = (st_q == ST_SEND)  && (cnt_q == CNT_W'(WR_CYC - 1));
  wire is_cmd     = fetch_done && !pend_q;
  wire cmd_ok     = cmd_valid(fifo_din[7:0], NUM_PORTS);
  wire cmd_read   = is_cmd && cmd_ok && (cmd_op(fifo_din[7:0]) == OP_READ);

  assign byte_done = fetch_done;
  assign cmd_drop  = is_cmd && !cmd_ok;
  assign reg_we    = fetch_done && pend_q;
  assign reg_dir   = pend_dir_q;
  assign reg_port  = pend_port_q;
  assign reg_data  = fifo_din;
  assign look_port = cmd_port(fifo_din[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      rd_n_q      <= 1'b1;
      wr_n_q      <= 1'b1;
      pend_q      <= 1'b0;
      pend_dir_q  <= 1'b0;
      pend_port_q <= '0;
      reply_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!rxf_n) begin
            st_q   <= ST_FETCH;
            rd_n_q <= 1'b0;
            cnt_q  <= '0;
          end
        end
        ST_FETCH: begin
          if (fetch_done) begin
            rd_n_q <= 1'b1;
            st_q   <= ST_IDLE;
            if (pend_q) begin
              pend_q <= 1'b0;
            end else if (cmd_read) begin
              reply_q <= reply_byte;
              st_q    <= ST_WAIT_TX;
            end else if (cmd_ok) begin
              pend_q      <= 1'b1;
              pend_dir_q  <= (cmd_op(fifo_din[7:0]) == OP_SETDIR);
              pend_port_q <= cmd_port(fifo_din[7:0]);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT_TX: begin
          if (!txe_n) begin
            st_q   <= ST_SEND;
            wr_n_q <= 1'b0;
            cnt_q  <= '0;
          end
        end
        ST_SEND: begin
          if (send_done) begin
            wr_n_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_n         = rd_n_q;
  assign wr_n         = wr_n_q;
  assign fifo_dout    = reply_q;
  assign fifo_dout_oe = (st_q == ST_SEND);
endmodule

// File: rtl/gpio_fifo_expander.sv
`timescale 1ns/1ps
module gpio_fifo_expander #(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned RD_CYC    = 2,
  parameter int unsigned WR_CYC    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rxf_n,
  input  logic [PORT_W-1:0]           fifo_din,
  output logic                        rd_n,
  input  logic                        txe_n,
  output logic [PORT_W-1:0]           fifo_dout,
  output logic                        fifo_dout_oe,
  output logic                        wr_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);
  localparam int unsigned NPINS = NUM_PORTS * PORT_W;

  logic [NPINS-1:0]  pins_sync;
  logic [2:0]        look_port;
  logic [PORT_W-1:0] reply_byte;
  logic              reg_we, reg_dir, byte_done, cmd_drop;
  logic [2:0]        reg_port;
  logic [PORT_W-1:0] reg_data;

  gpx_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  always_comb begin
    reply_byte = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (look_port == 3'(p)) reply_byte = pins_sync[p*PORT_W +: PORT_W];
    end
  end

  gpx_fifo_ctrl #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rxf_n(rxf_n), .fifo_din(fifo_din), .rd_n(rd_n),
    .txe_n(txe_n), .fifo_dout(fifo_dout), .fifo_dout_oe(fifo_dout_oe), .wr_n(wr_n),
    .look_port(look_port), .reply_byte(reply_byte),
    .reg_we(reg_we), .reg_dir(reg_dir), .reg_port(reg_port), .reg_data(reg_data),
    .byte_done(byte_done), .cmd_drop(cmd_drop)
  );

  gpx_port_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .to_dir(reg_dir), .port(reg_port), .data(reg_data),
    .out_flat(pin_out), .oe_flat(pin_oe)
  );
endmodule

// File: rtl/gpx_checker.sv
`timescale 1ns/1ps
module gpx_checker #(
  parameter int unsigned NPINS  = 48,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxf_n,
  input logic              txe_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [PORT_W-1:0] fifo_dout,
  input logic              fifo_dout_oe,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              reg_we
);
  logic [7:0] rd_low_q, wr_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_low_q <= '0;
      wr_low_q <= '0;
    end else begin
      rd_low_q <= !rd_n ? ((rd_low_q == 8'hFF) ? rd_low_q : rd_low_q + 1'b1) : 8'h00;
      wr_low_q <= !wr_n ? ((wr_low_q == 8'hFF) ? wr_low_q : wr_low_q + 1'b1) : 8'h00;
    end
  end

  p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == '0 && pin_out == '0));

  p_write_at_strobe_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> $rose(rd_n));

  p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(pin_out) && $stable(pin_oe)));

  p_rd_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!rxf_n));

  p_rd_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_low_q == 8'(RD_CYC)));

  p_wr_needs_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(!txe_n));

  p_wr_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_low_q == 8'(WR_CYC)));

  p_wr_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(fifo_dout));

  p_wr_bus_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> fifo_dout_oe);

  p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
endmodule

bind gpio_fifo_expander gpx_checker #(
  .NPINS(NUM_PORTS*PORT_W), .PORT_W(PORT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .txe_n(txe_n),
  .rd_n(rd_n), .wr_n(wr_n), .fifo_dout(fifo_dout), .fifo_dout_oe(fifo_dout_oe),
  .pin_out(pin_out), .pin_oe(pin_oe), .reg_we(reg_we)
);

// File: tb/gpio_fifo_expander_bench.sv
`timescale 1ns/1ps
module gpio_fifo_expander_bench;
  localparam int NP = 6, PW = 8, RDC = 2, WRC = 3, NB = NP*PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxf_n = 1'b1, txe_n = 1'b0;
  logic [7:0] fifo_din = 8'h00;
  logic rd_n, wr_n, fifo_dout_oe;
  logic [7:0] fifo_dout;
  logic [NB-1:0] pin_in, pin_out, pin_oe;
  logic [NB-1:0] ext_drive = '0;

  always #10 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_drive);

  gpio_fifo_expander #(.NUM_PORTS(NP), .PORT_W(PW), .RD_CYC(RDC), .WR_CYC(WRC)) u_gpio_fifo_expander (
    .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .fifo_din(fifo_din), .rd_n(rd_n),
    .txe_n(txe_n), .fifo_dout(fifo_dout), .fifo_dout_oe(fifo_dout_oe), .wr_n(wr_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_vec = 0, n_bad = 0;
  int rd_falls = 0, wr_falls = 0, replies = 0, pushed = 0, cycles = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  logic [7:0] expq[$];
  logic [7:0] m_out[NP];
  logic [7:0] m_dir[NP];
  bit pend = 0; int pend_op = 0, pend_port = 0;
  logic prev_rd = 1'b1, prev_wr = 1'b1;
  logic [7:0] wr_byte = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] level(input int p);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = m_dir[p][i] ? ext_drive[p*8+i] : m_out[p][i];
    return v;
  endfunction

  // Protocol reference: interpret each byte as it is consumed.
  task automatic consume(input logic [7:0] b);
    int op, prt;
    if (pend) begin
      if (pend_op == 1) m_out[pend_port] = b; else m_dir[pend_port] = b;
      pend = 0;
    end else begin
      op = (b / 8) % 4; prt = b % 8;
      if (b >= 8'd32 || op == 3 || prt >= NP) begin
        // undefined: nothing happens (R10)
      end else if (op == 0) expq.push_back(level(prt));
      else begin pend = 1; pend_op = op; pend_port = prt; end
    end
  endtask

  function automatic logic [NB-1:0] exp_out();
    logic [NB-1:0] v;
    for (int p = 0; p < NP; p++) v[p*8 +: 8] = m_out[p];
    return v;
  endfunction

  function automatic logic [NB-1:0] exp_oe();
    logic [NB-1:0] v;
    for (int p = 0; p < NP; p++) v[p*8 +: 8] = ~m_dir[p];
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd && !rd_n) rd_falls++;
      if (prev_wr && !wr_n) wr_falls++;
      if (!rd_n) fifo_din = (rxq.size() > 0) ? rxq[0] : 8'h00;
      if (!prev_rd && rd_n) begin
        if (rxq.size() == 0) chk(0, "R8 fetch with empty fifo", 1, 0);
        else consume(rxq.pop_front());
      end
      rxf_n = (rxq.size() == 0);
      if (!wr_n) wr_byte = fifo_dout;
      if (!prev_wr && wr_n) begin
        replies++;
        if (expq.size() == 0) chk(0, "R7 unexpected reply", NB'(wr_byte), 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(wr_byte == e, "R4 R7 reply byte", NB'(wr_byte), NB'(e));
        end
      end
      chk(pin_out == exp_out(), "R3 R1 pin_out", pin_out, exp_out());
      chk(pin_oe == exp_oe(), "R5 R1 pin_oe", pin_oe, exp_oe());
      chk(rd_n || wr_n, "R11 strobes both low", {rd_n, wr_n}, 2'b11);
      prev_rd = rd_n; prev_wr = wr_n;
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rxq.push_back(b);
    pushed++;
  endtask

  task automatic drain();
    int t = 0;
    do begin
      @(negedge clk); t++;
    end while (!(rxq.size() == 0 && expq.size() == 0 && rd_n && wr_n) && t < 2000);
    if (t >= 2000) chk(0, "R7 drain timeout", 0, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int rep0, wf0;
    for (int p = 0; p < NP; p++) begin m_out[p] = 8'h00; m_dir[p] = 8'hFF; end
    repeat (4) @(negedge clk);
    chk(pin_oe == '0, "R6 reset oe", pin_oe, '0);
    chk(pin_out == '0, "R6 reset out", pin_out, '0);
    chk(rd_n && wr_n, "R6 reset strobes", {rd_n, wr_n}, 2'b11);
    rst_n = 1'b1;
    ext_drive = 48'hA5C3_3C5A_0FF0;
    repeat (5) @(negedge clk);

    // R7 R4: six reads in one burst, all pins inputs
    for (int p = 0; p < NP; p++) push(8'(p));
    drain();
    chk(replies == 6, "R7 six replies", NB'(replies), 6);

    // R3 R5 R2: set value 0x08|p, set direction 0x10|p
    push(8'h10); push(8'h00); push(8'h08); push(8'h12);
    push(8'h11); push(8'hF0); push(8'h09); push(8'hAB);
    push(8'h0D); push(8'h3C); push(8'h15); push(8'h0F);
    drain();
    chk(pin_out[7:0] == 8'h12, "R3 R1 port0 value", NB'(pin_out[7:0]), 8'h12);
    chk(pin_oe[7:0] == 8'hFF, "R5 port0 all outputs", NB'(pin_oe[7:0]), 8'hFF);
    chk(pin_oe[15:8] == 8'h0F, "R5 R1 port1 low nibble driven", NB'(pin_oe[15:8]), 8'h0F);
    chk(pin_out[47:40] == 8'h3C, "R1 R2 port5 value", NB'(pin_out[47:40]), 8'h3C);

    // R7 R4: read-after-write on port3, then read burst over mixed pins
    rep0 = replies;
    push(8'h13); push(8'h00); push(8'h0B); push(8'h77); push(8'h03);
    for (int p = 0; p < NP; p++) push(8'(p));
    drain();
    chk(pin_oe[31:24] == 8'hFF, "R5 port3 output", NB'(pin_oe[31:24]), 8'hFF);
    chk(replies == rep0 + 7, "R7 burst reply count", NB'(replies), NB'(rep0 + 7));

    // R9: no write while transmit flag is high
    rep0 = replies; wf0 = wr_falls;
    @(negedge clk); txe_n = 1'b1;
    push(8'h02);
    repeat (40) @(negedge clk);
    chk(wr_falls == wf0, "R9 no write while full", NB'(wr_falls), NB'(wf0));
    chk(!fifo_dout_oe, "R9 bus idle while full", NB'(fifo_dout_oe), 0);
    txe_n = 1'b0;
    drain();
    chk(replies == rep0 + 1, "R9 reply after space", NB'(replies), NB'(rep0 + 1));

    // R10: undefined commands are no-ops and consume no data byte
    push(8'h1A); push(8'h06); push(8'h0F); push(8'h2A); push(8'h17);
    push(8'h0A); push(8'h5A);
    drain();
    chk(pin_out[23:16] == 8'h5A, "R10 next byte is command", NB'(pin_out[23:16]), 8'h5A);
    chk(pin_out[47:40] == 8'h3C, "R10 port5 untouched", NB'(pin_out[47:40]), 8'h3C);
    chk(rd_falls == pushed, "R8 each byte fetched once", NB'(rd_falls), NB'(pushed));

    // R8: bytes trickled with gaps
    push(8'h0C); repeat (9) @(negedge clk); push(8'hC9); repeat (9) @(negedge clk);
    push(8'h14); repeat (7) @(negedge clk); push(8'h00);
    drain();
    chk(pin_out[39:32] == 8'hC9, "R8 trickled value", NB'(pin_out[39:32]), 8'hC9);
    chk(rd_falls == pushed, "R8 trickled fetch count", NB'(rd_falls), NB'(pushed));

    // R4: new external levels, restore inputs, read back
    push(8'h11); push(8'hFF);
    drain();
    ext_drive = 48'h1234_5678_9ABC;
    repeat (5) @(negedge clk);
    push(8'h01); push(8'h02); push(8'h00);
    drain();
    finish_run();
  end
endmodule